// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, in the same cycle as the access is presented, whether a memory access may proceed. Every access carries an address, an access type (data read, data write or instruction fetch) and a privilege flag. The decision is taken against a small table of programmable regions. Each region has its own enable, a base address, a power-of-two size, and six permission bits: read, write and execute, held separately for privileged and unprivileged code.

A refused access raises a single-cycle memory-management fault strobe together with a violation kind code. On the next clock edge the faulting address and kind are captured into holding registers and flagged valid, so that a fault handler can read them. Regions and the global enable are loaded through a plain write port. While the unit is globally disabled, every access is allowed and no fault is ever raised.

Region sizes are powers of two of at least 32 bytes, and each base is treated as aligned to its own size. Typical use is a no-access guard under a stack, a no-access page at address zero, read-and-execute-only code memory, and peripheral space that only privileged code may reach.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every region is disabled, the global enable is off and `flt_valid` is 0. With the global enable then set and no region written, a privileged access is allowed and an unprivileged access is refused.
- R2: While the global enable is off, `acc_allow` is 1 and `mm_fault` is 0 for every access, and nothing is captured.
- R3: A region covers addresses whose bits at and above position k match the base, where k is `cfg_size` clamped to a minimum of 5 (32 bytes). Base bits below k are ignored. A `cfg_size` of `ADDR_W` or more covers the whole address space.
- R4: `cfg_perm` bits are {unpriv exec, unpriv write, unpriv read, priv exec, priv write, priv read} from bit 5 down to bit 0. The access is granted by the bit that matches its privilege and its `acc_type` (00 read, 01 write, 10 or 11 execute).
- R5: A region with all permission bits clear refuses every access inside it, privileged or not.
- R6: When several enabled regions cover the address, the one with the highest index alone decides.
- R7: An access that no enabled region covers is allowed for privileged code and refused for unprivileged code.
- R8: A refused access with `acc_valid` high raises `mm_fault` in the same cycle, with `mm_kind` 01 for a data read, 10 for a data write and 11 for an instruction fetch. `mm_kind` is 00 when there is no fault.
- R9: One cycle after a fault, `flt_valid` is 1 and `flt_addr` and `flt_kind` hold that fault's address and kind. `flt_clr` clears `flt_valid` on the next edge. A fault in the same cycle as `flt_clr` wins.
- R10: A region or global-enable write takes effect from the next cycle. An access presented in the same cycle as the write is judged against the old table.
- R11: With `acc_valid` low, `mm_fault` is 0 and the captured fault state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | IDX_W | Region index to write |
| cfg_en | input | 1 | Region enable value |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size | input | SZ_W | Region size as log2 of bytes |
| cfg_perm | input | 6 | Region permission bits |
| glb_we | input | 1 | Global enable write strobe |
| glb_en | input | 1 | Global enable value |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access address |
| acc_type | input | 2 | 00 read, 01 write, 1x execute |
| acc_priv | input | 1 | Access is privileged |
| flt_clr | input | 1 | Clear captured fault valid flag |
| acc_allow | output | 1 | Access permitted (combinational) |
| mm_fault | output | 1 | Fault strobe (combinational) |
| mm_kind | output | 2 | Fault kind code (combinational) |
| flt_valid | output | 1 | Captured fault is valid |
| flt_addr | output | ADDR_W | Captured fault address |
| flt_kind | output | 2 | Captured fault kind |

## Verification
Two pairs of events can fall in one cycle. The first is a region write and an access that the write would change. The second is a fault capture and a clear of the captured state. The bench presents a refused unprivileged access in the same cycle as a write that opens a covering region, and expects the refusal and fault then, and an allow on the very next cycle. It also raises `flt_clr` together with a faulting access and expects `flt_valid` to stay set, holding the new address and kind.

// File: rtl/mpu_region_check.sv
module mpu_region_check #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int MIN_LOG2    = 5,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int SZ_W       = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic [5:0]        cfg_perm,
  input  logic              glb_we,
  input  logic              glb_en,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_type,
  input  logic              acc_priv,
  input  logic              flt_clr,
  output logic              acc_allow,
  output logic              mm_fault,
  output logic [1:0]        mm_kind,
  output logic              flt_valid,
  output logic [ADDR_W-1:0] flt_addr,
  output logic [1:0]        flt_kind
);

  logic              glb_q;
  logic              en_q   [NUM_REGIONS];
  logic [ADDR_W-1:0] base_q [NUM_REGIONS];
  logic [SZ_W-1:0]   size_q [NUM_REGIONS];
  logic [5:0]        perm_q [NUM_REGIONS];

  function automatic logic [ADDR_W-1:0] region_mask(input logic [SZ_W-1:0] s);
    int e;
    logic [ADDR_W-1:0] m;
    e = (int'(s) < MIN_LOG2) ? MIN_LOG2 : int'(s);
    for (int b = 0; b < ADDR_W; b++) m[b] = (b >= e);
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        en_q[i]   <= 1'b0;
        base_q[i] <= '0;
        size_q[i] <= '0;
        perm_q[i] <= '0;
      end
    end else begin
      if (glb_we) glb_q <= glb_en;
      if (cfg_we) begin
        en_q[cfg_idx]   <= cfg_en;
        base_q[cfg_idx] <= cfg_base;
        size_q[cfg_idx] <= cfg_size;
        perm_q[cfg_idx] <= cfg_perm;
      end
    end
  end

  logic              any_hit;
  logic [5:0]        sel_perm;
  logic [1:0]        tix;
  logic [ADDR_W-1:0] m;

  always_comb begin
    any_hit  = 1'b0;
    sel_perm = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      m = region_mask(size_q[i]);
      if (en_q[i] && ((acc_addr & m) == (base_q[i] & m))) begin
        any_hit  = 1'b1;
        sel_perm = perm_q[i];
      end
    end
  end

  assign tix = acc_type[1] ? 2'd2 : {1'b0, acc_type[0]};

  logic granted, permit;
  assign granted   = acc_priv ? sel_perm[tix] : sel_perm[3 + int'(tix)];
  assign permit    = any_hit ? granted : acc_priv;
  assign acc_allow = !glb_q || permit;
  assign mm_fault  = acc_valid && glb_q && !permit;
  assign mm_kind   = mm_fault ? tix + 2'd1 : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_kind  <= '0;
    end else if (mm_fault) begin
      flt_valid <= 1'b1;
      flt_addr  <= acc_addr;
      flt_kind  <= mm_kind;
    end else if (flt_clr) begin
      flt_valid <= 1'b0;
    end
  end

  // R2
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q |-> (acc_allow && !mm_fault));

  // R8
  fault_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_fault |-> (!acc_allow && acc_valid && mm_kind != 2'd0));

  // R9
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_fault |=> (flt_valid && flt_addr == $past(acc_addr) && flt_kind == $past(mm_kind)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && !mm_fault) |=> !flt_valid);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(flt_addr) && $stable(flt_kind) && (flt_valid || !$past(flt_valid) || $past(flt_clr))));

endmodule

// File: tb/mpu_region_check_test.sv
`timescale 1ns/100ps
module mpu_region_check_test;
  localparam int NR = 8;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int SW = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, glb_we = 0, glb_en = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_size = '0;
  logic [5:0] cfg_perm = '0;
  logic acc_valid = 0, acc_priv = 0, flt_clr = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_type = '0;
  logic acc_allow, mm_fault, flt_valid;
  logic [1:0] mm_kind, flt_kind;
  logic [AW-1:0] flt_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mpu_region_check #(.NUM_REGIONS(NR), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_perm(cfg_perm),
    .glb_we(glb_we), .glb_en(glb_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_type(acc_type), .acc_priv(acc_priv), .flt_clr(flt_clr),
    .acc_allow(acc_allow), .mm_fault(mm_fault), .mm_kind(mm_kind),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_kind(flt_kind));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_region(input int idx, input logic en, input logic [AW-1:0] b,
                           input int sz, input logic [5:0] p);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_en = en; cfg_base = b; cfg_size = SW'(sz); cfg_perm = p;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_glb(input logic v);
    @(negedge clk); glb_we = 1; glb_en = v;
    @(negedge clk); glb_we = 0;
  endtask

  task automatic drive(input logic v, input logic p, input logic [1:0] t, input logic [AW-1:0] a);
    @(negedge clk);
    acc_valid = v; acc_priv = p; acc_type = t; acc_addr = a;
    #1;
  endtask

  task automatic idle_clear;
    @(negedge clk); acc_valid = 0; flt_clr = 1;
    @(negedge clk); flt_clr = 0;
  endtask

  // {priv, type, addr, allow, kind}
  localparam logic [37:0] VEC [18] = '{
    {1'b1, 2'd0, 32'h2000_0100, 1'b1, 2'd0},
    {1'b0, 2'd1, 32'h2000_0104, 1'b1, 2'd0},
    {1'b0, 2'd2, 32'h2000_0100, 1'b0, 2'd3},
    {1'b1, 2'd1, 32'h2000_1010, 1'b0, 2'd2},
    {1'b1, 2'd0, 32'h2000_101F, 1'b0, 2'd1},
    {1'b1, 2'd0, 32'h2000_1020, 1'b1, 2'd0},
    {1'b0, 2'd0, 32'h0800_1234, 1'b1, 2'd0},
    {1'b1, 2'd1, 32'h0800_0000, 1'b0, 2'd2},
    {1'b0, 2'd3, 32'h080F_FFFC, 1'b1, 2'd0},
    {1'b1, 2'd0, 32'h0000_0000, 1'b0, 2'd1},
    {1'b1, 2'd2, 32'h0000_00FF, 1'b0, 2'd3},
    {1'b1, 2'd0, 32'h0000_0100, 1'b1, 2'd0},
    {1'b0, 2'd0, 32'h0000_0100, 1'b0, 2'd1},
    {1'b1, 2'd1, 32'h4000_0010, 1'b1, 2'd0},
    {1'b0, 2'd0, 32'h4000_0010, 1'b0, 2'd1},
    {1'b0, 2'd1, 32'h3000_001F, 1'b1, 2'd0},
    {1'b0, 2'd1, 32'h3000_0020, 1'b0, 2'd2},
    {1'b0, 2'd0, 32'h3000_0000, 1'b1, 2'd0}
  };

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 flt_valid after reset", 64'(flt_valid), 64'd0);
    rst_n = 1;
    drive(1, 0, 2'd0, 32'h0000_0000);
    check("R1 allow while globally off", 64'(acc_allow), 64'd1);

    wr_glb(1);
    drive(1, 0, 2'd0, 32'h2000_0000);
    check("R1 R7 unpriv with empty table", 64'(acc_allow), 64'd0);
    drive(1, 1, 2'd1, 32'h2000_0000);
    check("R1 R7 priv with empty table", 64'(acc_allow), 64'd1);
    idle_clear();

    wr_region(0, 1, 32'h2000_0000, 16, 6'b011_011);
    wr_region(1, 1, 32'h0800_0000, 20, 6'b101_101);
    wr_region(2, 1, 32'h2000_1000, 5,  6'b000_000);
    wr_region(3, 1, 32'h0000_0000, 8,  6'b000_000);
    wr_region(4, 1, 32'h4000_0000, 20, 6'b000_011);
    wr_region(5, 1, 32'h3000_0013, 2,  6'b111_111);

    wr_glb(0);
    drive(1, 0, 2'd2, 32'h0000_0000);
    check("R2 allow when disabled", 64'(acc_allow), 64'd1);
    check("R2 no fault when disabled", 64'(mm_fault), 64'd0);
    @(posedge clk); #1;
    check("R2 nothing captured", 64'(flt_valid), 64'd0);
    wr_glb(1);

    foreach (VEC[i]) begin
      logic [37:0] v;
      v = VEC[i];
      drive(1, v[37], v[36:35], v[34:3]);
      check($sformatf("R3 R4 R5 R6 R7 allow vec %0d", i), 64'(acc_allow), 64'(v[2]));
      check($sformatf("R8 fault vec %0d", i), 64'(mm_fault), 64'(!v[2]));
      check($sformatf("R8 kind vec %0d", i), 64'(mm_kind), 64'(v[1:0]));
      @(posedge clk); #1;
      if (!v[2]) begin
        check($sformatf("R9 valid vec %0d", i), 64'(flt_valid), 64'd1);
        check($sformatf("R9 addr vec %0d", i), 64'(flt_addr), 64'(v[34:3]));
        check($sformatf("R9 kind vec %0d", i), 64'(flt_kind), 64'(v[1:0]));
      end
    end

    idle_clear();
    #1 check("R9 clear drops valid", 64'(flt_valid), 64'd0);

    drive(1, 0, 2'd0, 32'h0000_0400);
    flt_clr = 1;
    @(posedge clk); #1;
    flt_clr = 0;
    check("R9 fault wins over clear valid", 64'(flt_valid), 64'd1);
    check("R9 fault wins over clear addr", 64'(flt_addr), 64'h0000_0400);
    check("R9 fault wins over clear kind", 64'(flt_kind), 64'd1);

    idle_clear();
    drive(0, 1, 2'd1, 32'h0800_0000);
    check("R11 no strobe without valid", 64'(mm_fault), 64'd0);
    @(posedge clk); #1;
    check("R11 nothing captured without valid", 64'(flt_valid), 64'd0);

    drive(1, 0, 2'd0, 32'h0000_0200);
    cfg_we = 1; cfg_idx = 3'd6; cfg_en = 1; cfg_base = 32'h0; cfg_size = 6'd12; cfg_perm = 6'b111_111;
    #0.5;
    check("R10 old table in write cycle", 64'(acc_allow), 64'd0);
    check("R10 fault in write cycle", 64'(mm_fault), 64'd1);
    @(posedge clk); #1;
    cfg_we = 0;
    check("R10 new region next cycle", 64'(acc_allow), 64'd1);
    check("R10 no fault next cycle", 64'(mm_fault), 64'd0);

    wr_region(2, 0, 32'h2000_1000, 5, 6'b000_000);
    drive(1, 1, 2'd1, 32'h2000_1010);
    check("R6 R10 guard disabled falls to lower region", 64'(acc_allow), 64'd1);
    drive(1, 0, 2'd0, 32'h1234_5678);
    wr_region(7, 1, 32'h0, 32, 6'b111_111);
    drive(1, 0, 2'd2, 32'h1234_5678);
    check("R3 whole-space region", 64'(acc_allow), 64'd1);

    acc_valid = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule